// File: doc/BRIEF.md
# Second-Order Multi-Rate CIC Decimator

This block takes a narrow sample stream that arrives at the full clock rate, such as the one-bit output of a digital mixer, and reduces it to a wide word at a much lower rate. It is a second-order cascaded integrator-comb filter built only from adders, subtractors and registers. The decimation ratio is a power-of-two parameter, 256 by default.

Two running-sum integrators advance on every accepted input sample. After every RATIO accepted samples, a downsampler captures the last integrator. It passes that value to two first-difference (comb) stages, which therefore do work only once per output word. The integrators and the combs are all as wide as the output. They wrap modulo 2^ACC_W, and the combs cancel that wrap exactly.

A one-bit input is read as a bipolar value. A wider input is read as a two's complement number. The filter has a sinc² response with droop, and it makes no attempt to correct it. Later stages are expected to correct droop and to sharpen the cutoff.

Top module: `cic2_decimator`

## Requirements
- R1: `out_valid` is high for exactly one clock cycle per output word, and exactly one word is produced per RATIO accepted input samples (floor of accepted/RATIO words since reset).
- R2: With IN_W = 1, an input bit of 1 enters the filter as +1 and a bit of 0 enters as −1.
- R3: With IN_W > 1, `in_data` is a two's complement signed sample and is sign-extended to ACC_W bits.
- R4: The output matches this model, with all arithmetic modulo 2^ACC_W:
  - ACC_W = SAMP_W + 2·log2(RATIO). SAMP_W is 2 when IN_W = 1 and IN_W otherwise.
  - For each accepted sample x, first S2 += S1 using the old S1, then S1 += x.
  - After every RATIO-th accepted sample, take the updated S2. Then D = S2 − S2prev and out = D − Dprev. All history starts at 0.
  - `out_data` is that value read as a signed ACC_W-bit number, and it stays correct after the integrators wrap.
- R5: With a constant input of +1 from reset, the first word is RATIO·(RATIO−1)/2 and every later word is RATIO². With −1, the signs of both values are inverted.
- R6: A cycle with `in_valid` low is ignored. Its `in_data` does not affect any later output, and no filter state or sample count advances.
- R7: `out_valid` is high in the cycle that follows the third rising edge after the edge that accepts the RATIO-th sample of a frame.
- R8: Synchronous active-high `rst` clears all integrator, downsampler, comb and phase state. While reset is held, and until the first new word, `out_valid` is 0 and `out_data` is 0. After reset, words follow the model from a fresh start.
- R9: `out_data` holds its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the fast and decimated sections |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_data` holds a sample to accept |
| in_data | input | IN_W | Input sample: bipolar bit when IN_W = 1, else two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new output word |
| out_data | output | ACC_W | Signed decimated output word |

## Verification
The embedded assertions check the following on every cycle: the single-cycle output pulse, the fixed three-cycle distance from the decimation tick to `out_valid`, and that the phase counter wraps after the last sample of a frame. They also check that the phase counter, integrators, comb delays and `out_data` stay frozen when they have no valid input. The bench scenarios are what show the arithmetic. Constant +1 and −1 runs give the closed-form values RATIO·(RATIO−1)/2 and RATIO². A 6-bit instance checks that its extreme codes reach the output range limits. Gapped random streams carrying junk data in idle cycles must match the bench's own two-sum, two-difference model, and a mid-frame reset must restart the sequence from the first-word value.

// File: rtl/cic_pkg.sv
package cic_pkg;

   // Number of integrator stages and of comb stages
   localparam int CIC_ORDER = 2;

   // Largest decimation ratio the phase counter is sized for
   localparam int CIC_MAX_RATIO = 65536;

   // True when v is a power of two of at least 2
   function automatic bit ratio_is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // Sample width after input mapping: a single bit needs room for +1 and -1
   function automatic int mapped_width(input int in_w);
      return (in_w == 1) ? 2 : in_w;
   endfunction

endpackage

// File: rtl/cic_in_map.sv
module cic_in_map #(
   parameter int IN_W  = 1,
   parameter int ACC_W = 18
) (
   input  logic [IN_W-1:0]  raw,
   output logic [ACC_W-1:0] ext
);

   generate
      if (ACC_W <= IN_W) begin : g_bad_width
         $error("cic_in_map: ACC_W must exceed IN_W");
      end

      if (IN_W == 1) begin : g_bipolar
         // R2: bit 1 -> +1, bit 0 -> -1 (all ones)
         assign ext = raw[0] ? ACC_W'(1) : {ACC_W{1'b1}};
      end else begin : g_twos
         // R3: two's complement sign extension
         assign ext = {{(ACC_W - IN_W){raw[IN_W-1]}}, raw};
      end
   endgenerate

endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] acc
);

   generate
      if (W < 2) begin : g_bad_width
         $error("cic_integ: W must be at least 2");
      end
   endgenerate

   // Modular running sum; wrap is cancelled by the comb section
   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
      end else if (en) begin
         acc <= acc + din;
      end
   end

   AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc)); // R6

endmodule

// File: rtl/cic_phase.sv
module cic_phase
   import cic_pkg::*;
#(
   parameter int RATIO = 256
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);

   localparam int PH_W = $clog2(RATIO);
   localparam logic [PH_W-1:0] LAST = PH_W'(RATIO - 1);

   generate
      if (!ratio_is_pow2(RATIO)) begin : g_bad_ratio
         $error("cic_phase: RATIO must be a power of two of at least 2");
      end
      if (RATIO > CIC_MAX_RATIO) begin : g_big_ratio
         $error("cic_phase: RATIO exceeds the supported maximum");
      end
   endgenerate

   logic [PH_W-1:0] phase;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= en && (phase == LAST);
         if (en) begin
            phase <= phase + 1'b1;
         end
      end
   end

   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
      (en && phase == LAST) |=> (phase == '0)); // R1

   AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(phase)); // R6

endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         vin,
   input  logic [W-1:0] din,
   output logic         vout,
   output logic [W-1:0] dout
);

   logic [W-1:0] dly;

   // First difference at the decimated rate
   always_ff @(posedge clk) begin
      if (rst) begin
         dly  <= '0;
         dout <= '0;
         vout <= 1'b0;
      end else begin
         vout <= vin;
         if (vin) begin
            dly  <= din;
            dout <= din - dly;
         end
      end
   end

   AST_COMB_HOLD: assert property (@(posedge clk) disable iff (rst)
      !vin |=> ($stable(dly) && $stable(dout))); // R9

endmodule

// File: rtl/cic2_decimator.sv
module cic2_decimator
   import cic_pkg::*;
#(
   parameter int IN_W  = 1,
   parameter int RATIO = 256,
   localparam int SAMP_W = mapped_width(IN_W),
   localparam int ACC_W  = SAMP_W + CIC_ORDER * $clog2(RATIO)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [IN_W-1:0]         in_data,
   output logic                    out_valid,
   output logic signed [ACC_W-1:0] out_data
);

   generate
      if (IN_W < 1) begin : g_bad_in_w
         $error("cic2_decimator: IN_W must be at least 1");
      end
   endgenerate

   // Fast-rate section: input mapping and integrator chain
   logic [CIC_ORDER:0][ACC_W-1:0] int_bus;

   cic_in_map #(.IN_W(IN_W), .ACC_W(ACC_W)) u_map (
      .raw (in_data),
      .ext (int_bus[0])
   );

   generate
      for (genvar k = 0; k < CIC_ORDER; k++) begin : g_integ
         cic_integ #(.W(ACC_W)) u_integ (
            .clk (clk),
            .rst (rst),
            .en  (in_valid),
            .din (int_bus[k]),
            .acc (int_bus[k+1])
         );
      end
   endgenerate

   // Downsampler: capture the last integrator once per RATIO samples
   logic tick;

   cic_phase #(.RATIO(RATIO)) u_phase (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .tick (tick)
   );

   logic [ACC_W-1:0] samp;
   logic             samp_v;

   always_ff @(posedge clk) begin
      if (rst) begin
         samp   <= '0;
         samp_v <= 1'b0;
      end else begin
         samp_v <= tick;
         if (tick) begin
            samp <= int_bus[CIC_ORDER];
         end
      end
   end

   // Slow-rate section: comb chain
   logic [CIC_ORDER:0][ACC_W-1:0] comb_bus;
   logic [CIC_ORDER:0]            comb_v;

   assign comb_bus[0] = samp;
   assign comb_v[0]   = samp_v;

   generate
      for (genvar k = 0; k < CIC_ORDER; k++) begin : g_comb
         cic_comb #(.W(ACC_W)) u_comb (
            .clk  (clk),
            .rst  (rst),
            .vin  (comb_v[k]),
            .din  (comb_bus[k]),
            .vout (comb_v[k+1]),
            .dout (comb_bus[k+1])
         );
      end
   endgenerate

   assign out_valid = comb_v[CIC_ORDER];
   assign out_data  = signed'(comb_bus[CIC_ORDER]);

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid); // R1

   AST_TICK_LATENCY: assert property (@(posedge clk) disable iff (rst)
      tick |-> ##3 out_valid); // R7

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (out_valid || $stable(out_data))); // R9

endmodule

// File: tb/tb_cic2_decimator.sv
module tb_cic2_decimator;

   localparam int CLK_PERIOD = 10;

   // Instance A: one-bit input, nominal ratio
   localparam int RA = 256;
   localparam int WA = 1;
   localparam int AA = 2 + 2 * 8;
   // Instance B: 6-bit signed input, small ratio
   localparam int RB = 8;
   localparam int WB = 6;
   localparam int AB = 6 + 2 * 3;

   logic clk = 1'b0;
   logic rst = 1'b1;

   logic                 a_v = 1'b0;
   logic [WA-1:0]        a_d = '0;
   logic                 a_ov;
   logic signed [AA-1:0] a_od;

   logic                 b_v = 1'b0;
   logic [WB-1:0]        b_d = '0;
   logic                 b_ov;
   logic signed [AB-1:0] b_od;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cic2_decimator #(.IN_W(WA), .RATIO(RA)) dut (
      .clk (clk), .rst (rst), .in_valid (a_v), .in_data (a_d),
      .out_valid (a_ov), .out_data (a_od)
   );

   cic2_decimator #(.IN_W(WB), .RATIO(RB)) dut_b (
      .clk (clk), .rst (rst), .in_valid (b_v), .in_data (b_d),
      .out_valid (b_ov), .out_data (b_od)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   longint s1 [2];
   longint s2 [2];
   longint p2 [2];
   longint p1 [2];
   int     ph [2];
   int     acc_cnt [2];
   int     pulses [2];
   longint qa [$];
   longint qb [$];
   longint got_a [$];
   longint got_b [$];
   longint last_a, last_b;
   bit     prev_a, prev_b;

   function automatic longint wrapw(input longint v, input int w);
      longint m;
      m = v & ((64'sd1 <<< w) - 1);
      if (m[w-1]) m = m - (64'sd1 <<< w);
      return m;
   endfunction

   task automatic model_step(input int i, input longint x, input int r, input int w);
      longint d1, o;
      s2[i] = wrapw(s2[i] + s1[i], w);
      s1[i] = wrapw(s1[i] + x, w);
      acc_cnt[i]++;
      ph[i]++;
      if (ph[i] == r) begin
         ph[i] = 0;
         d1 = wrapw(s2[i] - p2[i], w);
         p2[i] = s2[i];
         o = wrapw(d1 - p1[i], w);
         p1[i] = d1;
         if (i == 0) qa.push_back(o);
         else        qb.push_back(o);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 2; i++) begin
         s1[i] = 0; s2[i] = 0; p1[i] = 0; p2[i] = 0;
         ph[i] = 0; acc_cnt[i] = 0; pulses[i] = 0;
      end
      qa.delete(); qb.delete(); got_a.delete(); got_b.delete();
      last_a = 0; last_b = 0; prev_a = 0; prev_b = 0;
   endtask

   // ---------------- output monitors ----------------
   always @(negedge clk) begin
      if (!rst) begin
         if (a_ov) begin
            pulses[0]++;
            chk(!prev_a, "R1 A pulse longer than one cycle", 1, 0);
            if (qa.size() == 0) begin
               chk(1'b0, "R1 A unexpected output word", longint'(a_od), 0);
            end else begin
               longint e;
               e = qa.pop_front();
               chk(longint'(a_od) == e, "R4 A word vs model", longint'(a_od), e);
            end
            got_a.push_back(longint'(a_od));
            last_a = longint'(a_od);
         end else begin
            chk(longint'(a_od) == last_a, "R9 A hold between pulses", longint'(a_od), last_a);
         end
         prev_a = a_ov;

         if (b_ov) begin
            pulses[1]++;
            chk(!prev_b, "R1 B pulse longer than one cycle", 1, 0);
            if (qb.size() == 0) begin
               chk(1'b0, "R1 B unexpected output word", longint'(b_od), 0);
            end else begin
               longint e;
               e = qb.pop_front();
               chk(longint'(b_od) == e, "R4 B word vs model", longint'(b_od), e);
            end
            got_b.push_back(longint'(b_od));
            last_b = longint'(b_od);
         end else begin
            chk(longint'(b_od) == last_b, "R9 B hold between pulses", longint'(b_od), last_b);
         end
         prev_b = b_ov;
      end
   end

   // ---------------- drivers ----------------
   task automatic drive_a(input bit v, input bit d);
      @(negedge clk);
      a_v = v;
      a_d = d;
      if (v) model_step(0, d ? 64'sd1 : -64'sd1, RA, AA);
   endtask

   task automatic drive_b(input bit v, input logic [WB-1:0] d);
      @(negedge clk);
      b_v = v;
      b_d = d;
      if (v) model_step(1, longint'($signed(d)), RB, AB);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      a_v = 1'b0;
      b_v = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // R8: reset clears outputs on both instances
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      a_v = 1'b0;
      b_v = 1'b0;
      repeat (3) @(negedge clk);
      chk(a_ov == 1'b0, "R8 A out_valid in reset", longint'(a_ov), 0);
      chk(a_od == '0, "R8 A out_data in reset", longint'(a_od), 0);
      chk(b_ov == 1'b0, "R8 B out_valid in reset", longint'(b_ov), 0);
      chk(b_od == '0, "R8 B out_data in reset", longint'(b_od), 0);
      model_clear();
      rst = 1'b0;
   endtask

   // R5 / R2: constant bipolar input, closed-form words
   task automatic t_const_a(input bit d, input int nout);
      longint first, steady;
      do_reset();
      repeat (RA * nout) drive_a(1'b1, d);
      idle(8);
      first  = longint'(RA) * (RA - 1) / 2;
      steady = longint'(RA) * RA;
      if (!d) begin
         first  = -first;
         steady = -steady;
      end
      chk(got_a.size() == nout, "R1 A word count for constant input", got_a.size(), nout);
      if (got_a.size() == nout) begin
         chk(got_a[0] == first, d ? "R5 first word for +1" : "R2 first word for bit 0",
             got_a[0], first);
         for (int k = 1; k < nout; k++)
            chk(got_a[k] == steady, d ? "R5 steady word for +1 (R4 wrap)" : "R2 steady word for bit 0",
                got_a[k], steady);
      end
   endtask

   // R6: idle cycles carrying the opposite bit must not disturb the +1 result
   task automatic t_idle_ignored();
      do_reset();
      for (int k = 0; k < RA * 3; k++) begin
         drive_a(1'b1, 1'b1);
         if (k % 3 == 0) drive_a(1'b0, 1'b0);
         if (k % 7 == 0) begin
            drive_a(1'b0, 1'b0);
            drive_a(1'b0, 1'b1);
         end
      end
      idle(8);
      chk(got_a.size() == 3, "R6 word count with idle cycles", got_a.size(), 3);
      if (got_a.size() == 3) begin
         chk(got_a[0] == longint'(RA) * (RA - 1) / 2, "R6 first word with idle junk",
             got_a[0], longint'(RA) * (RA - 1) / 2);
         chk(got_a[2] == longint'(RA) * RA, "R6 third word with idle junk",
             got_a[2], longint'(RA) * RA);
      end
   endtask

   // R4 / R6 / R1: random bits with random gaps
   task automatic t_gaps_a();
      do_reset();
      while (acc_cnt[0] < RA * 12 + RA / 3) begin
         drive_a(($urandom % 3) != 0, 1'($urandom));
      end
      idle(8);
      chk(pulses[0] == acc_cnt[0] / RA, "R1 A pulses per accepted samples", pulses[0], acc_cnt[0] / RA);
      chk(qa.size() == 0, "R4 A pending model words", qa.size(), 0);
   endtask

   // R7: latency from the accepting edge of the last sample
   task automatic t_latency();
      do_reset();
      repeat (RA) drive_a(1'b1, 1'b1);
      @(negedge clk);
      a_v = 1'b0;
      chk(a_ov == 1'b0, "R7 out_valid after edge 0", longint'(a_ov), 0);
      @(negedge clk);
      chk(a_ov == 1'b0, "R7 out_valid after edge 1", longint'(a_ov), 0);
      @(negedge clk);
      chk(a_ov == 1'b0, "R7 out_valid after edge 2", longint'(a_ov), 0);
      @(negedge clk);
      chk(a_ov == 1'b1, "R7 out_valid after edge 3", longint'(a_ov), 1);
      @(negedge clk);
      chk(a_ov == 1'b0, "R7 out_valid after edge 4", longint'(a_ov), 0);
   endtask

   // R8: reset in the middle of a frame restarts the sequence
   task automatic t_mid_reset();
      do_reset();
      repeat (RA / 2 + 5) drive_a(1'b1, 1'b0);
      do_reset();
      repeat (RA * 2) drive_a(1'b1, 1'b1);
      idle(8);
      chk(got_a.size() == 2, "R8 word count after mid-frame reset", got_a.size(), 2);
      if (got_a.size() == 2)
         chk(got_a[0] == longint'(RA) * (RA - 1) / 2, "R8 first word after mid-frame reset",
             got_a[0], longint'(RA) * (RA - 1) / 2);
   endtask

   // R3: multi-bit constant at the code extremes
   task automatic t_const_b(input int val, input int nout);
      longint first, steady;
      do_reset();
      repeat (RB * nout) drive_b(1'b1, WB'(val));
      idle(8);
      first  = longint'(val) * RB * (RB - 1) / 2;
      steady = longint'(val) * RB * RB;
      chk(got_b.size() == nout, "R3 B word count", got_b.size(), nout);
      if (got_b.size() == nout) begin
         chk(got_b[0] == first, "R3 B first word", got_b[0], first);
         chk(got_b[nout-1] == steady, "R3 B steady word", got_b[nout-1], steady);
      end
   endtask

   // R3 / R4 / R6: random signed samples with gaps
   task automatic t_rand_b();
      do_reset();
      while (acc_cnt[1] < RB * 40) begin
         drive_b(($urandom % 4) != 0, WB'($urandom));
      end
      idle(8);
      chk(pulses[1] == acc_cnt[1] / RB, "R1 B pulses per accepted samples", pulses[1], acc_cnt[1] / RB);
      chk(qb.size() == 0, "R4 B pending model words", qb.size(), 0);
   endtask

   bit finished = 1'b0;

   initial begin
      do_reset();
      t_const_a(1'b1, 6);
      t_const_a(1'b0, 4);
      t_idle_ignored();
      t_gaps_a();
      t_latency();
      t_mid_reset();
      t_const_b(31, 4);
      t_const_b(-32, 4);
      t_rand_b();
      idle(4);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (120000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule